// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Even-Parity Check

This block turns an asynchronous serial line into bytes. The line idles high. Each frame has a low start bit, eight data bits with the least significant bit first, one even-parity bit, and a high stop bit. The block runs from a 50 MHz system clock. An internal divider makes a tick at sixteen times the 115200 line rate, which is one tick every 27 clocks. The block watches the synchronized line on each tick and treats a high-to-low change as the possible start of a frame.

When a start is seen, the block waits half a bit time and checks that the line is still low, which rejects glitches. It then samples once per bit, at the middle of each bit. It shifts in the data, folds the data into a running XOR, and checks the parity bit and the stop bit. At the sample taken in the stop-bit slot, it loads the byte and both error flags into the output registers and raises a ready flag. The ready flag stays high until the consumer pulses an acknowledge. A later frame replaces the outputs whether or not the earlier one was acknowledged.

Top module: `uart_rx_parity`

## Requirements
- R1: After synchronous reset, `rx_ready`, `par_err` and `frm_err` are 0 and `rx_byte` is 0x00. They stay that way while the line idles high.
- R2: One oversample tick occurs every `DIV` clocks and one bit lasts 16 ticks. `rx_ready` rises between 168·`DIV` + 1 and 168·`DIV` + `DIV` + 4 clocks after the line first goes low for a valid frame. That is the middle of the stop bit.
- R3: The frame is a 0 start bit, then 8 data bits, then a parity bit, then a stop bit. The first data bit after the start bit lands in `rx_byte[0]` and the last lands in `rx_byte[7]`.
- R4: Parity is even. `par_err` is 1 exactly when the received parity bit differs from the XOR of the eight data bits. For example, 0x52 needs parity bit 1 and 0x53 needs parity bit 0.
- R5: `frm_err` is 1 exactly when the stop-bit sample is 0. The byte is still delivered in that case.
- R6: If the line is high again at the midpoint of the start bit, the frame is dropped. `rx_ready` does not rise, and the next valid frame is received normally.
- R7: A one-cycle `rd_ack` clears `rx_ready` on the next clock. It leaves `rx_byte`, `par_err` and `frm_err` unchanged.
- R8: A completed frame always reloads `rx_byte`, `par_err` and `frm_err` and sets `rx_ready`, even if the previous frame was never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_ack | input | 1 | One-cycle pulse that clears `rx_ready` |
| rx_byte | output | 8 | Last received byte |
| rx_ready | output | 1 | A byte is waiting to be read |
| par_err | output | 1 | Parity mismatch on the last frame |
| frm_err | output | 1 | Stop bit was 0 on the last frame |

## Verification
An error in the tick divider or the half-bit preload moves the sample points. This shows at the ports as `rx_ready` rising outside its narrow window, and as wrong bits in `rx_byte` once the drift exceeds half a bit, all within the first frame. An error in the shift direction, the parity accumulator or the bit-slot decoding shows as a wrong `rx_byte` or a wrong flag on the very frame it affects. The bench sweeps all 256 byte values, so every data pattern meets the parity and shift logic. A stale glitch or busy state shows up as a missing or early `rx_ready` on the frame that follows it.

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
  parameter int DIV = 27,
  parameter int OSR = 16,
  parameter int NB  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_line,
  input  logic          rd_ack,
  output logic [NB-1:0] rx_byte,
  output logic          rx_ready,
  output logic          par_err,
  output logic          frm_err
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(NB + 3);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);
  localparam logic [TW-1:0] HALF     = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] FULL     = TW'(OSR - 1);
  localparam logic [BW-1:0] LAST_D   = BW'(NB);
  localparam logic [BW-1:0] PAR_IDX  = BW'(NB + 1);
  localparam logic [BW-1:0] STOP_IDX = BW'(NB + 2);

  logic [1:0]    sync;
  logic [CW-1:0] os_cnt;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic [NB-1:0] sh;
  logic          line_prev, busy, acc, perr;

  wire rx_s    = sync[1];
  wire os_tick = (os_cnt == DIV_LAST);
  wire sample  = os_tick && busy && (tcnt == '0);
  wire done    = sample && (bidx == STOP_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync      <= 2'b11;
      os_cnt    <= '0;
      line_prev <= 1'b1;
      busy      <= 1'b0;
      tcnt      <= '0;
      bidx      <= '0;
      sh        <= '0;
      acc       <= 1'b0;
      perr      <= 1'b0;
      rx_byte   <= '0;
      rx_ready  <= 1'b0;
      par_err   <= 1'b0;
      frm_err   <= 1'b0;
    end else begin
      sync   <= {sync[0], rx_line};
      os_cnt <= os_tick ? '0 : os_cnt + 1'b1;
      if (rd_ack) rx_ready <= 1'b0;
      if (os_tick) begin
        line_prev <= rx_s;
        if (!busy) begin
          if (line_prev && !rx_s) begin
            busy <= 1'b1;
            tcnt <= HALF;
            bidx <= '0;
            acc  <= 1'b0;
          end
        end else if (tcnt != '0) begin
          tcnt <= tcnt - 1'b1;
        end else begin
          tcnt <= FULL;
          bidx <= bidx + 1'b1;
          if (bidx == '0) begin
            if (rx_s) busy <= 1'b0;
          end else if (bidx <= LAST_D) begin
            sh  <= {rx_s, sh[NB-1:1]};
            acc <= acc ^ rx_s;
          end else if (bidx == PAR_IDX) begin
            perr <= rx_s ^ acc;
          end else begin
            busy     <= 1'b0;
            rx_byte  <= sh;
            par_err  <= perr;
            frm_err  <= !rx_s;
            rx_ready <= 1'b1;
          end
        end
      end
    end
  end

  // R1
  idle_index_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bidx == '0 || bidx == STOP_IDX + 1'b1 || bidx == BW'(1)));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (os_tick && DIV > 1) |=> !os_tick);

  // R6
  glitch_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (sample && bidx == '0 && rx_s) |=> (!busy && !$rose(rx_ready)));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !done) |=> (!rx_ready && $stable(rx_byte) && $stable(par_err) && $stable(frm_err)));

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !rd_ack) |=> rx_ready);

  // R8
  flag_update_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(frm_err) || !$stable(par_err)) |-> rx_ready);

  // R8
  frame_load_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_ready);
endmodule

// File: tb/sim_uart_rx_parity.sv
module sim_uart_rx_parity;
  localparam int DIV = 2;
  localparam int B   = 16 * DIV;

  logic clk = 1'b0;
  logic rst, rx_line, rd_ack;
  logic [7:0] rx_byte;
  logic rx_ready, par_err, frm_err;
  int cyc = 0, n_chk = 0, n_fail = 0;
  logic prevr = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_rx_parity #(.DIV(DIV), .OSR(16), .NB(8)) u0 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rd_ack(rd_ack),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .par_err(par_err), .frm_err(frm_err));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit flip, input bit stopb, output int rel);
    logic [10:0] frm;
    int c0;
    frm = {stopb, (^d) ^ flip, d, 1'b0};
    rel = -1;
    c0 = cyc;
    prevr = rx_ready;
    for (int i = 0; i < 12; i++) begin
      rx_line = (i < 11) ? frm[i] : 1'b1;
      for (int k = 0; k < B; k++) begin
        @(negedge clk);
        if (rx_ready && !prevr && rel < 0) rel = cyc - c0;
        prevr = rx_ready;
      end
    end
  endtask

  task automatic ack_and_check(input logic [7:0] held);
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
    chk("R7 ready cleared", int'(rx_ready), 0);
    chk("R7 byte held", int'(rx_byte), int'(held));
  endtask

  function automatic int in_win(input int rel);
    return int'(rel >= 168 * DIV + 1 && rel <= 168 * DIV + DIV + 4);
  endfunction

  initial begin
    int rel;
    rst = 1'b1; rx_line = 1'b1; rd_ack = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset ready", int'(rx_ready), 0);
    chk("R1 reset byte", int'(rx_byte), 0);
    chk("R1 reset flags", int'({par_err, frm_err}), 0);
    rst = 1'b0;
    repeat (3 * B) @(negedge clk);
    chk("R1 idle ready", int'(rx_ready), 0);

    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b0, 1'b1, rel);
      chk("R3 byte", int'(rx_byte), v);
      chk("R4 parity ok", int'(par_err), 0);
      chk("R5 stop ok", int'(frm_err), 0);
      chk("R2 ready timing", in_win(rel), 1);
      if (v % 64 == 0) ack_and_check(8'(v));
      else begin
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
      end
    end

    send(8'h52, 1'b1, 1'b1, rel);
    chk("R4 bad parity 52", int'(par_err), 1);
    chk("R4 byte 52", int'(rx_byte), 'h52);
    ack_and_check(8'h52);
    chk("R7 flag held", int'(par_err), 1);
    send(8'h53, 1'b1, 1'b1, rel);
    chk("R4 bad parity 53", int'(par_err), 1);
    chk("R5 no frame err", int'(frm_err), 0);
    ack_and_check(8'h53);
    send(8'hFF, 1'b1, 1'b1, rel);
    chk("R4 bad parity FF", int'(par_err), 1);
    ack_and_check(8'hFF);

    send(8'hA5, 1'b0, 1'b0, rel);
    chk("R5 frame err", int'(frm_err), 1);
    chk("R5 byte kept", int'(rx_byte), 'hA5);
    chk("R5 parity clean", int'(par_err), 0);
    ack_and_check(8'hA5);
    chk("R7 frm held", int'(frm_err), 1);
    send(8'h3C, 1'b0, 1'b1, rel);
    chk("R8 flags reloaded", int'({par_err, frm_err}), 0);
    ack_and_check(8'h3C);

    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (13 * B) @(negedge clk);
    chk("R6 glitch dropped", int'(rx_ready), 0);
    chk("R6 byte untouched", int'(rx_byte), 'h3C);
    send(8'h96, 1'b0, 1'b1, rel);
    chk("R6 next frame byte", int'(rx_byte), 'h96);
    chk("R6 next frame timing", in_win(rel), 1);

    send(8'h11, 1'b0, 1'b1, rel);
    chk("R8 overwrite 1", int'(rx_byte), 'h11);
    send(8'h22, 1'b1, 1'b1, rel);
    chk("R8 overwrite byte", int'(rx_byte), 'h22);
    chk("R8 overwrite ready", int'(rx_ready), 1);
    chk("R8 overwrite parity", int'(par_err), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule